// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block sits between a master clock and the consumers of a chip's system and peripheral clocks. A phase bit flips on every master edge and forms a divided tick at half the master rate. The block turns that tick into clock-enable outputs for the core, the memory and each peripheral, plus a watchdog enable that is never gated. All gating is expressed as clock-enable pulses that are one master cycle wide, not as gated clock nets.

Three operating modes decide which enables pulse. Run drives all of them. Wait silences the core and memory but keeps the peripherals running, so an unmasked interrupt can return the block to Run. Stop silences everything except the watchdog. Stop is left only through bus-traffic activity or a non-clocked interrupt. The message carried by waking bus traffic is reported as lost. A per-peripheral enable register can also silence individual peripherals in any mode.

Mode changes land only at the end of a divided period. Single-cycle request and wake pulses are held until that boundary. Three reset sources all return the block to its initial state: an asynchronous power-on reset, an external reset and a watchdog reset.

Top module: `pm_clock_gater`

## Requirements
- R1: `wdog_ce` is low in the first cycle after any reset and then alternates every master cycle, in every mode. It is high in exactly one master cycle of every two.
- R2: In Run (`mode` = 2'b00), `core_ce`, `mem_ce` and every `per_ce[i]` whose enable bit is 1 are high exactly when `wdog_ce` is high.
- R3: In Wait (`mode` = 2'b01), `core_ce` and `mem_ce` stay low, while each enabled `per_ce[i]` still pulses with `wdog_ce`.
- R4: In Stop (`mode` = 2'b10), `core_ce`, `mem_ce` and all of `per_ce` stay low, while `wdog_ce` keeps alternating.
- R5: In Run, a `req_stop` pulse moves the block to Stop and a `req_wait` pulse moves it to Wait. When both are seen at the same boundary, Stop wins.
- R6: In Wait, an interrupt line with `irq[i]`=1 and `irq_mask[i]`=0 returns the block to Run. Masked lines (`irq_mask[i]`=1), `req_stop`, `bus_wake` and `nclk_irq` leave the block in Wait.
- R7: In Stop, only `bus_wake` or `nclk_irq` returns the block to Run. `irq` lines and both requests are ignored.
- R8: `msg_lost` changes only when the block leaves Stop. It becomes 1 if `bus_wake` took part in the wake and 0 if `nclk_irq` alone did. Every reset clears it.
- R9: Writing `pclk_wdata` with `pclk_wr`=1 loads the peripheral enable register on that edge. While bit i is 0, `per_ce[i]` stays low in every mode.
- R10: Any of `rst_n` low, `ext_rst` high or `wdog_rst` high at an edge resets the block. The mode becomes Run, all peripheral enable bits become 1, `msg_lost` becomes 0 and the divided phase restarts low.
- R11: `mode` changes only on the edge that ends a divided period, the edge after a cycle with `wdog_ce` high. A request or wake pulse lasting one master cycle in either phase still takes effect at the next such boundary.
- R12: A `req_stop` seen at a boundary together with an active `bus_wake` or `nclk_irq` is ignored, and the block stays in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous external reset, active high |
| wdog_rst | input | 1 | Synchronous watchdog reset, active high |
| req_wait | input | 1 | Request to enter Wait |
| req_stop | input | 1 | Request to enter Stop |
| irq | input | NIRQ | Clocked interrupt lines |
| irq_mask | input | NIRQ | Interrupt masks, 1 = masked |
| nclk_irq | input | 1 | Non-clocked interrupt (Stop wake source) |
| bus_wake | input | 1 | Bus-traffic activity (Stop wake source) |
| pclk_wr | input | 1 | Write strobe for the peripheral enable register |
| pclk_wdata | input | NPER | New peripheral enable bits |
| core_ce | output | 1 | Core clock enable |
| mem_ce | output | 1 | Memory clock enable |
| per_ce | output | NPER | Peripheral clock enables |
| wdog_ce | output | 1 | Ungated watchdog clock enable |
| mode | output | 2 | Current mode: 00 Run, 01 Wait, 10 Stop |
| msg_lost | output | 1 | The last Stop exit dropped a bus message |

## Verification
The bench runs scripted scenarios through each mode and then a long pseudo-random run. A reference model compares every output on every cycle against the requirements. Single-cycle pulses are placed in both phases of the divided clock, which shows whether events are held until the boundary or missed. Combined patterns test the priority and masking rules: Stop with a wake source present, masked against unmasked interrupts, bus traffic against a non-clocked wake. Rare peripheral-enable writes and resets arriving from all three sources tell per-bit gating apart from mode gating and show that every reset restores the same state.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10
  } pm_mode_e;

  // Positions inside the held event vector
  localparam int EV_WAIT = 0;
  localparam int EV_STOP = 1;
  localparam int EV_BUS  = 2;
  localparam int EV_NCLK = 3;
  localparam int EV_IRQ  = 4;
  localparam int EV_W    = 5;

  function automatic pm_mode_e pm_next(input pm_mode_e cur, input logic [EV_W-1:0] ev);
    logic stop_wake;
    stop_wake = ev[EV_BUS] | ev[EV_NCLK];
    case (cur)
      PM_RUN: begin
        if (ev[EV_STOP])      pm_next = stop_wake ? PM_RUN : PM_STOP;
        else if (ev[EV_WAIT]) pm_next = PM_WAIT;
        else                  pm_next = PM_RUN;
      end
      PM_WAIT: pm_next = ev[EV_IRQ] ? PM_RUN : PM_WAIT;
      PM_STOP: pm_next = stop_wake ? PM_RUN : PM_STOP;
      default: pm_next = PM_RUN;
    endcase
  endfunction

  function automatic logic pm_lost_next(input pm_mode_e cur, input logic [EV_W-1:0] ev,
                                        input logic lost);
    if (cur == PM_STOP && (ev[EV_BUS] | ev[EV_NCLK])) pm_lost_next = ev[EV_BUS];
    else                                              pm_lost_next = lost;
  endfunction

  function automatic logic pm_core_live(input pm_mode_e cur);
    pm_core_live = (cur == PM_RUN);
  endfunction

  function automatic logic pm_per_live(input pm_mode_e cur);
    pm_per_live = (cur != PM_STOP);
  endfunction

endpackage

// File: rtl/pmcg_phase.sv
module pmcg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rst,
  output logic tick,
  output logic bnd
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ph_q <= 1'b0;
    else if (sync_rst) ph_q <= 1'b0;
    else               ph_q <= ~ph_q;
  end

  assign tick = ph_q;
  assign bnd  = ph_q;
endmodule

// File: rtl/pmcg_event_hold.sv
module pmcg_event_hold #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_rst,
  input  logic         bnd,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] evt_eff
);
  logic [W-1:0] pend_q;

  for (genvar g = 0; g < W; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend_q[g] <= 1'b0;
      else if (sync_rst || bnd)  pend_q[g] <= 1'b0;
      else if (evt_i[g])         pend_q[g] <= 1'b1;
    end
    assign evt_eff[g] = pend_q[g] | evt_i[g];
  end
endmodule

// File: rtl/pmcg_mode_fsm.sv
module pmcg_mode_fsm
  import pmcg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_rst,
  input  logic            bnd,
  input  logic [EV_W-1:0] evt_eff,
  output pm_mode_e        mode_q,
  output logic            lost_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_RUN;
      lost_q <= 1'b0;
    end else if (sync_rst) begin
      mode_q <= PM_RUN;
      lost_q <= 1'b0;
    end else if (bnd) begin
      mode_q <= pm_next(mode_q, evt_eff);
      lost_q <= pm_lost_next(mode_q, evt_eff, lost_q);
    end
  end
endmodule

// File: rtl/pmcg_gate.sv
module pmcg_gate
  import pmcg_pkg::*;
#(
  parameter int NPER = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_rst,
  input  logic            tick,
  input  pm_mode_e        mode_q,
  input  logic            wr,
  input  logic [NPER-1:0] wdata,
  output logic [NPER-1:0] per_en_q,
  output logic            core_ce,
  output logic            mem_ce,
  output logic [NPER-1:0] per_ce
);
  logic core_live, per_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        per_en_q <= '1;
    else if (sync_rst) per_en_q <= '1;
    else if (wr)       per_en_q <= wdata;
  end

  assign core_live = pm_core_live(mode_q);
  assign per_live  = pm_per_live(mode_q);
  assign core_ce   = tick & core_live;
  assign mem_ce    = tick & core_live;

  for (genvar i = 0; i < NPER; i++) begin : g_per
    assign per_ce[i] = tick & per_live & per_en_q[i];
  end
endmodule

// File: rtl/pm_clock_gater.sv
module pm_clock_gater
  import pmcg_pkg::*;
#(
  parameter int NPER = 8,
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_rst,
  input  logic            wdog_rst,
  input  logic            req_wait,
  input  logic            req_stop,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic            nclk_irq,
  input  logic            bus_wake,
  input  logic            pclk_wr,
  input  logic [NPER-1:0] pclk_wdata,
  output logic            core_ce,
  output logic            mem_ce,
  output logic [NPER-1:0] per_ce,
  output logic            wdog_ce,
  output logic [1:0]      mode,
  output logic            msg_lost
);
  logic            sync_rst;
  logic            tick, bnd;
  logic            irq_hit;
  logic [EV_W-1:0] evt_now, evt_eff;
  logic            bus_eff;
  pm_mode_e        mode_q;
  logic            lost_q;
  logic [NPER-1:0] per_en_q;

  assign sync_rst = ext_rst | wdog_rst;
  assign irq_hit  = |(irq & ~irq_mask);

  always_comb begin
    evt_now          = '0;
    evt_now[EV_WAIT] = req_wait;
    evt_now[EV_STOP] = req_stop;
    evt_now[EV_BUS]  = bus_wake;
    evt_now[EV_NCLK] = nclk_irq;
    evt_now[EV_IRQ]  = irq_hit;
  end

  pmcg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .tick(tick), .bnd(bnd)
  );

  pmcg_event_hold #(.W(EV_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .bnd(bnd),
    .evt_i(evt_now), .evt_eff(evt_eff)
  );

  pmcg_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .bnd(bnd),
    .evt_eff(evt_eff), .mode_q(mode_q), .lost_q(lost_q)
  );

  pmcg_gate #(.NPER(NPER)) u_gate (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .tick(tick), .mode_q(mode_q),
    .wr(pclk_wr), .wdata(pclk_wdata), .per_en_q(per_en_q),
    .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce)
  );

  assign bus_eff  = evt_eff[EV_BUS];
  assign wdog_ce  = tick;
  assign mode     = mode_q;
  assign msg_lost = lost_q;
endmodule

// File: rtl/pm_clock_gater_chk.sv
module pm_clock_gater_chk #(
  parameter int NPER = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sync_rst,
  input logic            bnd,
  input logic            bus_eff,
  input logic [1:0]      mode,
  input logic            core_ce,
  input logic            mem_ce,
  input logic [NPER-1:0] per_ce,
  input logic [NPER-1:0] per_en,
  input logic            wdog_ce,
  input logic            msg_lost
);
  // R1
  wdog_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_rst |=> (wdog_ce != $past(wdog_ce)));

  // R3
  wait_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!core_ce && !mem_ce));

  // R4
  stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!core_ce && !mem_ce && per_ce == '0));

  // R9
  per_bit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ce & ~per_en) == '0);

  // R11
  mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_rst && !bnd) |=> $stable(mode));

  // R8
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_rst && bnd && mode == 2'b10 && bus_eff) |=> msg_lost);

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |=> (mode == 2'b00 && !msg_lost && (&per_en) && !wdog_ce));
endmodule

bind pm_clock_gater pm_clock_gater_chk #(.NPER(NPER)) i_chk (
  .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .bnd(bnd), .bus_eff(bus_eff),
  .mode(mode), .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce),
  .per_en(per_en_q), .wdog_ce(wdog_ce), .msg_lost(msg_lost)
);

// File: tb/test_pm_clock_gater.sv
module test_pm_clock_gater;
  localparam int NP = 4;
  localparam int NI = 2;

  logic clk = 1'b0;
  logic rst_n, ext_rst, wdog_rst, req_wait, req_stop, nclk_irq, bus_wake, pclk_wr;
  logic [NI-1:0] irq, irq_mask;
  logic [NP-1:0] pclk_wdata, per_ce;
  logic core_ce, mem_ce, wdog_ce, msg_lost;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  pm_clock_gater #(.NPER(NP), .NIRQ(NI)) i_pm_clock_gater (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wdog_rst(wdog_rst),
    .req_wait(req_wait), .req_stop(req_stop), .irq(irq), .irq_mask(irq_mask),
    .nclk_irq(nclk_irq), .bus_wake(bus_wake), .pclk_wr(pclk_wr), .pclk_wdata(pclk_wdata),
    .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce), .wdog_ce(wdog_ce),
    .mode(mode), .msg_lost(msg_lost)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Reference model: phase, mode, enables, lost flag and held events,
  // built from the requirement text.
  logic       m_ph, m_lost;
  logic [1:0] m_mode;
  logic [NP-1:0] m_en;
  logic [4:0] m_pend;

  always @(posedge clk or negedge rst_n) begin
    logic [4:0] ev, now;
    logic wake;
    if (!rst_n || ext_rst || wdog_rst) begin
      m_ph = 0; m_mode = 2'b00; m_en = '1; m_lost = 0; m_pend = '0;
    end else begin
      now  = {|(irq & ~irq_mask), nclk_irq, bus_wake, req_stop, req_wait};
      ev   = m_pend | now;
      wake = ev[2] | ev[3];
      if (pclk_wr) m_en = pclk_wdata;
      if (m_ph) begin
        case (m_mode)
          2'b00: if (ev[1]) m_mode = wake ? 2'b00 : 2'b10;
                 else if (ev[0]) m_mode = 2'b01;
          2'b01: if (ev[4]) m_mode = 2'b00;
          default: if (wake) begin m_lost = ev[2]; m_mode = 2'b00; end
        endcase
        m_pend = '0;
      end else m_pend = m_pend | now;
      m_ph = ~m_ph;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    string mt;
    logic exp_core;
    logic [NP-1:0] exp_per;
    mt = (m_mode == 2'b00) ? "R2" : (m_mode == 2'b01) ? "R3" : "R4";
    exp_core = m_ph && (m_mode == 2'b00);
    exp_per  = (m_ph && m_mode != 2'b10) ? m_en : '0;
    check(wdog_ce == m_ph, "R1", "wdog_ce", wdog_ce, m_ph);
    check(core_ce == exp_core && mem_ce == exp_core, mt, "core/mem",
          {core_ce, mem_ce}, {exp_core, exp_core});
    check(per_ce == exp_per, {mt, " R9"}, "per_ce", per_ce, exp_per);
    check(mode == m_mode, "R5 R6 R7 R11 R12", "mode", mode, m_mode);
    check(msg_lost == m_lost, "R8", "msg_lost", msg_lost, m_lost);
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_evt(input int which);
    case (which)
      0: req_wait = 1; 1: req_stop = 1; 2: bus_wake = 1; default: nclk_irq = 1;
    endcase
    cyc();
    req_wait = 0; req_stop = 0; bus_wake = 0; nclk_irq = 0;
  endtask

  task automatic per_seen(output logic [NP-1:0] seen, output bit core_seen);
    seen = '0; core_seen = 0;
    repeat (2) begin
      seen = seen | per_ce; core_seen = core_seen | core_ce;
      cyc();
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] seen;
    bit cs;
    rst_n = 0; ext_rst = 0; wdog_rst = 0; req_wait = 0; req_stop = 0;
    nclk_irq = 0; bus_wake = 0; pclk_wr = 0; pclk_wdata = '0; irq = '0; irq_mask = '0;
    cyc(3);
    rst_n = 1;
    #1;
    // R10 reset state
    check(mode == 2'b00 && msg_lost == 0, "R10", "mode/lost after reset", {mode, msg_lost}, 0);
    check(wdog_ce == 0, "R1", "first tick low", wdog_ce, 0);
    cmp_on = 1;
    cyc();
    check(wdog_ce && core_ce && mem_ce && per_ce == 4'hF, "R2", "run pulses",
          {wdog_ce, core_ce, mem_ce, per_ce}, 7'h7F);

    // R12: stop request with bus traffic present
    req_stop = 1; bus_wake = 1; cyc(); req_stop = 0; bus_wake = 0;
    cyc(3);
    check(mode == 2'b00, "R12", "stop with wake ignored", mode, 0);

    // R5 / R4 / R7 / R8: stop then bus wake
    pulse_evt(1); cyc(3);
    check(mode == 2'b10, "R5", "enter stop", mode, 2);
    per_seen(seen, cs);
    check(seen == 0 && !cs, "R4", "stop silences", {cs, seen}, 0);
    req_wait = 1; irq = 2'b01; cyc(); req_wait = 0; irq = 0; cyc(3);
    check(mode == 2'b10, "R7", "irq/wait ignored in stop", mode, 2);
    pulse_evt(2); cyc(3);
    check(mode == 2'b00 && msg_lost, "R8", "bus wake marks lost", {mode, msg_lost}, 1);
    pulse_evt(1); cyc(3); pulse_evt(3); cyc(3);
    check(mode == 2'b00 && !msg_lost, "R8", "nclk wake clears lost", {mode, msg_lost}, 0);

    // R5 priority: both requests -> stop
    req_wait = 1; req_stop = 1; cyc(); req_wait = 0; req_stop = 0; cyc(3);
    check(mode == 2'b10, "R5", "stop beats wait", mode, 2);
    pulse_evt(3); cyc(3);

    // R3 / R6: wait, masked irq ignored, unmasked irq wakes
    pulse_evt(0); cyc(3);
    check(mode == 2'b01, "R5", "enter wait", mode, 1);
    per_seen(seen, cs);
    check(seen == 4'hF && !cs, "R3", "wait keeps peripherals", {cs, seen}, 4'hF);
    irq = 2'b01; irq_mask = 2'b01; cyc(); pulse_evt(1); pulse_evt(2); irq = 0; cyc(3);
    check(mode == 2'b01, "R6", "masked irq ignored", mode, 1);
    irq = 2'b10; cyc(); irq = 0; irq_mask = 0; cyc(3);
    check(mode == 2'b00, "R6", "unmasked irq wakes", mode, 0);

    // R9: per-bit enable
    pclk_wr = 1; pclk_wdata = 4'b0101; cyc(); pclk_wr = 0;
    per_seen(seen, cs);
    check(seen == 4'b0101, "R9", "per-bit gating", seen, 4'b0101);

    // R10: external and watchdog resets
    ext_rst = 1; cyc(); ext_rst = 0;
    check(wdog_ce == 0 && mode == 2'b00, "R10", "ext reset phase/mode", {wdog_ce, mode}, 0);
    per_seen(seen, cs);
    check(seen == 4'hF, "R10", "ext reset restores enables", seen, 4'hF);
    pclk_wr = 1; pclk_wdata = 4'b0000; cyc(); pclk_wr = 0;
    pulse_evt(1); cyc(3); wdog_rst = 1; cyc(); wdog_rst = 0;
    check(mode == 2'b00 && !msg_lost, "R10", "watchdog reset", {mode, msg_lost}, 0);
    per_seen(seen, cs);
    check(seen == 4'hF, "R10", "watchdog reset enables", seen, 4'hF);

    // R11: one-cycle pulses in both phases, plus model-compared random run
    for (int ph = 0; ph < 2; ph++) begin
      cyc(ph);
      pulse_evt(1); cyc(3);
      check(mode == 2'b10, "R11", "pulse held to boundary", mode, 2);
      pulse_evt(3); cyc(3);
    end

    for (int k = 0; k < 20000; k++) begin
      rng = nxt(rng);
      req_wait = (rng[2:0] == 0);
      req_stop = (rng[5:3] == 0);
      bus_wake = (rng[9:6] == 0);
      nclk_irq = (rng[13:10] == 0);
      irq      = (rng[16:14] == 0) ? rng[18:17] : '0;
      if (rng[23:19] == 0) irq_mask = rng[25:24];
      pclk_wr  = (rng[30:26] == 0);
      pclk_wdata = rng[3:0] ^ rng[31:28];
      ext_rst  = (rng[31:22] == 0);
      wdog_rst = (rng[21:12] == 10'h3FF);
      rst_n    = !(rng[31:20] == 12'hABC);
      cyc();
    end
    rst_n = 1; ext_rst = 0; wdog_rst = 0; cyc(2);
    cmp_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule